// File: doc/BRIEF.md
# PWM Shadow Register Update Controller

This block keeps two copies of every PWM configuration register: the period, six compare values, the 12-bit action qualifier, the breath period and the 24-bit hold count. Writes from a simple address/data/strobe port always land in the shadow copy. The active copy is the one the waveform generator uses, and it takes the shadow value according to one of three transfer policies.

In immediate mode, a write reaches the active copy at once. In separate mode, each register has its own enable, and a register with its enable set copies its shadow on its timing strobe. That strobe is the period-boundary pulse for the period, compare and action-qualifier registers, and the end-of-breath pulse for the breath-period and hold registers. In synchronize-all mode, software first writes the group members and then writes the period. The period write arms a grouped transfer, which fires on the period-boundary strobe in flicker operation and on the end-of-breath strobe in breath operation. A busy flag shows that an armed transfer is pending.

Address map, also used as the bit index into the separate-enable vector: 0 period, 1 compare A0, 2 compare A1, 3 compare B0, 4 compare B1, 5 compare C0, 6 compare C1, 7 breath period, 8 hold, 9 action qualifier.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset the active period reads 100, and every other active register reads 0. busy_o reads 0.
- R2: A write to an address of 10 or more changes no register. A write to the hold or action-qualifier register keeps only the low 24 or 12 bits of the data.
- R3: With sync_all_i=0 and sep_en_i[a]=0, a write to address a shows on the matching active output one cycle after the write edge.
- R4: With sync_all_i=0 and sep_en_i[a]=1, a write to address a leaves the active output unchanged. The shadow value is copied on the next period_tick_i for addresses 0–6 and 9, and on the next breath_end_i for addresses 7 and 8.
- R5: With sync_all_i=1 and breath_mode_i=0, writes stay in the shadow copies until a write to address 0 has armed the transfer. On the next period_tick_i, the period, all compares and the action qualifier load together. The breath period and hold do not load.
- R6: With sync_all_i=1 and breath_mode_i=1, a write to address 0 or 7 arms the transfer. On the next breath_end_i, the period, breath period and hold load together. The compares and the action qualifier do not load.
- R7: busy_o rises in the cycle after an arming write and falls in the cycle after the grouped transfer. In synchronize-all mode a strobe with nothing armed transfers nothing.
- R8: In synchronize-all mode the strobe that does not belong to the current breath setting leaves an armed transfer pending and changes no active register.
- R9: Clearing sync_all_i drops a pending armed transfer: busy_o falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Register address (0–9) |
| wr_data_i | input | DATA_W | Write data |
| sync_all_i | input | 1 | Selects synchronize-all transfer |
| sep_en_i | input | 10 | Per-register separate-update enable, indexed by address |
| breath_mode_i | input | 1 | Breath operation selected |
| period_tick_i | input | 1 | Counter at period minus one |
| breath_end_i | input | 1 | Breath process has ended |
| period_o | output | DATA_W | Active period |
| cmp_o | output | 6*DATA_W | Active compares, A0 in the lowest slice up to C1 |
| aq_o | output | AQ_W | Active action qualifier |
| brprd_o | output | DATA_W | Active breath period |
| hold_o | output | HOLD_W | Active hold count |
| busy_o | output | 1 | Synchronize-all transfer armed and pending |

## Verification
The bench builds the block with its default widths: 32-bit data, a 12-bit action qualifier, a 24-bit hold and a 4-bit address. With a 4-bit address, random writes reach the unused addresses 10–15 as well as all ten registers. Random data with all-ones corners exercises the truncation of the narrow registers. Random mode switches, enable vectors and strobes, some of them arriving in the same cycle as a write, exercise every transfer path. Directed cases cover arming, wrong-strobe waits and dropping an armed transfer.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int NREG      = 10;
  localparam int N_CMP     = 6;
  localparam int IDX_PRD   = 0;
  localparam int IDX_CMP0  = 1;
  localparam int IDX_BRPRD = 7;
  localparam int IDX_HOLD  = 8;
  localparam int IDX_AQ    = 9;

  // registers timed by the end-of-breath strobe
  function automatic logic on_breath_strobe(input int idx);
    return (idx == IDX_BRPRD) || (idx == IDX_HOLD);
  endfunction

  function automatic logic in_flicker_grp(input int idx);
    return !on_breath_strobe(idx);
  endfunction

  function automatic logic in_breath_grp(input int idx);
    return (idx == IDX_PRD) || on_breath_strobe(idx);
  endfunction
endpackage

// File: rtl/pwm_shadow_arm.sv
module pwm_shadow_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic arm_i,
  input  logic fire_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (!en_i)   pend_q <= 1'b0;
    else if (arm_i)   pend_q <= 1'b1;
    else if (fire_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(arm_i && en_i));
  assert_busy_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !arm_i) |=> !pend_q);
  assert_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);
endmodule

// File: rtl/pwm_shadow_slot.sv
module pwm_shadow_slot #(
  parameter int         W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_now_i,
  input  logic         xfer_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= RST;
    else if (wr_i) shadow_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   active_q <= RST;
    else if (xfer_i)               active_q <= shadow_q;
    else if (wr_i && load_now_i)   active_q <= wdata_i;
  end

  assign active_o = active_q;

  assert_xfer_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> active_q == $past(shadow_q));
  assert_immediate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && load_now_i && !xfer_i) |=> active_q == $past(wdata_i));
  assert_hold_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !(wr_i && load_now_i)) |=> $stable(active_q));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AQ_W    = 12,
  parameter int HOLD_W  = 24,
  parameter int ADDR_W  = 4,
  parameter int PRD_RST = 100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    sync_all_i,
  input  logic [NREG-1:0]         sep_en_i,
  input  logic                    breath_mode_i,
  input  logic                    period_tick_i,
  input  logic                    breath_end_i,
  output logic [DATA_W-1:0]       period_o,
  output logic [N_CMP*DATA_W-1:0] cmp_o,
  output logic [AQ_W-1:0]         aq_o,
  output logic [DATA_W-1:0]       brprd_o,
  output logic [HOLD_W-1:0]       hold_o,
  output logic                    busy_o
);
  logic [NREG-1:0] wr_hit, xfer, load_now;
  logic arm, fire_flk, fire_br, pend;

  assign arm = sync_all_i &&
               (wr_hit[IDX_PRD] || (breath_mode_i && wr_hit[IDX_BRPRD]));
  assign fire_flk = pend && period_tick_i && !breath_mode_i;
  assign fire_br  = pend && breath_end_i && breath_mode_i;

  pwm_shadow_arm u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sync_all_i),
    .arm_i  (arm),
    .fire_i (fire_flk || fire_br),
    .pend_o (pend)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int SW = (i == IDX_AQ) ? AQ_W : (i == IDX_HOLD) ? HOLD_W : DATA_W;
    localparam logic [SW-1:0] RV = (i == IDX_PRD) ? SW'(PRD_RST) : '0;
    logic [SW-1:0] act_w;
    logic          strobe;

    assign wr_hit[i]   = wr_en_i && (wr_addr_i == ADDR_W'(i));
    assign strobe      = on_breath_strobe(i) ? breath_end_i : period_tick_i;
    assign load_now[i] = !sync_all_i && !sep_en_i[i];
    assign xfer[i]     = sync_all_i
                         ? ((in_flicker_grp(i) && fire_flk) || (in_breath_grp(i) && fire_br))
                         : (sep_en_i[i] && strobe);

    pwm_shadow_slot #(.W(SW), .RST(RV)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_hit[i]),
      .wdata_i    (wr_data_i[SW-1:0]),
      .load_now_i (load_now[i]),
      .xfer_i     (xfer[i]),
      .active_o   (act_w)
    );

    if (i == IDX_PRD) begin : g_prd
      assign period_o = act_w;
    end else if (i == IDX_BRPRD) begin : g_brprd
      assign brprd_o = act_w;
    end else if (i == IDX_HOLD) begin : g_hold
      assign hold_o = act_w;
    end else if (i == IDX_AQ) begin : g_aq
      assign aq_o = act_w;
    end else begin : g_cmp
      assign cmp_o[(i-IDX_CMP0)*DATA_W +: DATA_W] = act_w;
    end
  end

  assign busy_o = pend;

  assert_idle_no_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_all_i && !busy_o) |-> xfer == '0);
  assert_wrong_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_all_i && busy_o && !arm && !(breath_mode_i ? breath_end_i : period_tick_i))
      |=> busy_o);
endmodule

// File: tb/pwm_shadow_ctrl_bench.sv
module pwm_shadow_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sa = 0, br = 0, tick = 0, bend = 0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NREG-1:0] sep = '0;
  logic [DW-1:0] period, brprd;
  logic [6*DW-1:0] cmp;
  logic [11:0] aq;
  logic [23:0] hold;
  logic busy;

  int checks = 0, errors = 0;
  logic [DW-1:0] sh [NREG];
  logic [DW-1:0] ac [NREG];
  logic pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_ctrl u_pwm_shadow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
    .sync_all_i(sa), .sep_en_i(sep), .breath_mode_i(br), .period_tick_i(tick),
    .breath_end_i(bend), .period_o(period), .cmp_o(cmp), .aq_o(aq), .brprd_o(brprd),
    .hold_o(hold), .busy_o(busy));

  function automatic logic [DW-1:0] mask_of(input int i);
    return (i == 9) ? 32'hFFF : (i == 8) ? 32'hFF_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [DW-1:0] got(input int i);
    case (i)
      0: return period;
      7: return brprd;
      8: return {8'h0, hold};
      9: return {20'h0, aq};
      default: return cmp[(i-1)*DW +: DW];
    endcase
  endfunction

  function automatic string tag_of(input int i);
    if (sa) return br ? "R6" : "R5";
    return sep[i] ? "R4" : "R3";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      sh[i] = (i == 0) ? 32'd100 : 32'd0;
      ac[i] = sh[i];
    end
    pend = 0;
  endtask

  // model of one clock edge, from the requirement text
  task automatic model_step();
    logic arm, ff, fb, x, bst;
    logic [DW-1:0] old_sh [NREG];
    arm = sa && wr_en && (addr == 0 || (br && addr == 7));
    ff = sa && pend && tick && !br;
    fb = sa && pend && bend && br;
    for (int i = 0; i < NREG; i++) old_sh[i] = sh[i];
    for (int i = 0; i < NREG; i++) begin
      bst = (i == 7 || i == 8);
      if (sa) x = (!bst && ff) || ((i == 0 || bst) && fb);
      else    x = sep[i] && (bst ? bend : tick);
      if (x) ac[i] = old_sh[i];
      else if (!sa && !sep[i] && wr_en && addr == 4'(i)) ac[i] = wdata & mask_of(i);
      if (wr_en && addr == 4'(i)) sh[i] = wdata & mask_of(i);
    end
    if (!sa) pend = 0;
    else if (arm) pend = 1;
    else if (ff || fb) pend = 0;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string why);
    for (int i = 0; i < NREG; i++) check({why, ":", tag_of(i)}, got(i), ac[i]);
    check({why, ":R7"}, {31'h0, busy}, {31'h0, pend});
  endtask

  // one cycle: inputs set before, model stepped at edge, outputs checked at negedge
  task automatic cyc(input logic w, input logic [3:0] a, input logic [DW-1:0] d,
                     input logic t, input logic b);
    wr_en = w; addr = a; wdata = d; tick = t; bend = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0; tick = 0; bend = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("r1_period", period, 32'd100);
    check("r1_cmp", cmp[DW-1:0] | cmp[5*DW +: DW], 0);
    check("r1_busy", {31'h0, busy}, 0);
    check_all("R1");

    // R2: unused address and truncation, immediate mode
    sa = 0; sep = '0;
    cyc(1, 4'd12, 32'hDEAD_BEEF, 0, 0); check_all("R2_addr12");
    cyc(1, 4'd9, 32'hFFFF_FFFF, 0, 0); check("R2_aq", {20'h0, aq}, 32'hFFF);
    cyc(1, 4'd8, 32'hFFFF_FFFF, 0, 0); check("R2_hold", {8'h0, hold}, 32'hFF_FFFF);
    // R3 immediate
    cyc(1, 4'd3, 32'h1234, 0, 0); check("R3_cmpb0", cmp[2*DW +: DW], 32'h1234);
    // R4 separate
    sep = 10'b00_1000_0010;
    cyc(1, 4'd1, 32'h55, 0, 0); check("R4_wait", cmp[DW-1:0], 32'h0);
    cyc(1, 4'd7, 32'h77, 0, 0); check("R4_wait_br", brprd, 32'h0);
    cyc(0, 0, 0, 0, 1); check("R4_br_first", cmp[DW-1:0], 32'h0);
    check("R4_brprd", brprd, 32'h77);
    cyc(0, 0, 0, 1, 0); check("R4_tick", cmp[DW-1:0], 32'h55);
    // R5 sync-all flicker
    sa = 1; br = 0;
    cyc(1, 4'd2, 32'hAA, 1, 0); check("R5_no_arm", cmp[DW +: DW], 32'h0);
    check("R7_idle", {31'h0, busy}, 0);
    cyc(1, 4'd7, 32'h99, 0, 0);
    cyc(1, 4'd0, 32'd200, 0, 0); check("R7_rise", {31'h0, busy}, 1);
    cyc(0, 0, 0, 0, 1); check("R8_flk", {31'h0, busy}, 1);
    check("R8_flk_prd", period, 32'd100);
    cyc(0, 0, 0, 1, 0);
    check("R5_prd", period, 32'd200); check("R5_cmp", cmp[DW +: DW], 32'hAA);
    check("R5_brprd", brprd, 32'h77); check("R7_fall", {31'h0, busy}, 0);
    // R6 sync-all breath
    br = 1;
    cyc(1, 4'd8, 32'h42, 0, 0);
    cyc(1, 4'd7, 32'h80, 0, 0); check("R6_arm", {31'h0, busy}, 1);
    cyc(0, 0, 0, 1, 0); check("R8_br", {31'h0, busy}, 1); check("R8_br_hold", {8'h0, hold}, 32'hFF_FFFF);
    cyc(1, 4'd4, 32'hCC, 0, 1);
    check("R6_hold", {8'h0, hold}, 32'h42); check("R6_brprd", brprd, 32'h80);
    check("R6_cmp", cmp[3*DW +: DW], 32'h0);
    // R9 drop
    cyc(1, 4'd0, 32'd300, 0, 0); check("R9_armed", {31'h0, busy}, 1);
    sa = 0; sep = '1;
    cyc(0, 0, 0, 0, 0); check("R9_drop", {31'h0, busy}, 0);
    check_all("R9");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] a; logic [DW-1:0] d; int r;
      if ($urandom_range(0, 49) == 0) sa = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) br = $urandom_range(0, 1);
      if ($urandom_range(0, 39) == 0) sep = 10'($urandom);
      r = $urandom_range(0, 7);
      a = 4'($urandom_range(0, 15));
      d = (r == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0);
      check_all("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule